// File: doc/BRIEF.md
# Pairwise Widening Add-Accumulate Unit

This unit takes a 128-bit source vector and splits it into narrow lanes of 8, 16 or 32 bits. It adds each neighbouring pair of lanes, elements 2k and 2k+1, into one result lane of twice the width. Before the add, each element is either sign-extended or zero-extended. When accumulation is selected, every widened sum is also added to the lane in the same position of a second 128-bit input, the old destination. That add wraps within the lane.

In half-vector mode only the low 64 source bits contribute, and the upper 64 bits of the result are forced to zero. This holds even when accumulating.

Operations enter through a valid/ready handshake, one per cycle, and the result appears one cycle later in an output register. The output is held until it is accepted. A lane-size code of 3 is illegal. It produces a one-cycle error pulse instead of a result.

Top module: `pwa_widen_acc`

## Requirements
- R1: Result lane k, of width 2N, equals the extended source element 2k plus the extended source element 2k+1, where N is the source lane width. Element i occupies bits [i*N +: N].
- R2: With is_unsigned=1 each source element is zero-extended to 2N bits; with is_unsigned=0 it is sign-extended.
- R3: lane_size selects N: code 0 gives 8 bits, code 1 gives 16 bits, code 2 gives 32 bits.
- R4: With accumulate=1, the 2N-bit lane k of dst is added to each pair sum, modulo 2^(2N). No carry crosses a lane boundary, in either the pair add or the accumulate add.
- R5: With full_vec=0, only src[63:0] affects the result, and result[127:64] is zero even when accumulate=1. With full_vec=1 both halves are processed.
- R6: When an operation with lane_size=3 is accepted, out_err is high for exactly the following cycle. out_valid is low in that cycle and result keeps its previous value.
- R7: An operation is accepted when in_valid and in_ready are both high, and in_ready is high whenever out_valid is low or out_ready is high. A legal accepted operation sets out_valid in the next cycle, with its result on the output.
- R8: While out_valid is high and out_ready is low, out_valid and result stay unchanged and in_ready is low.
- R9: After reset, out_valid=0, out_err=0, result=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Unit can take an operation this cycle |
| src | input | 128 | Source vector of narrow lanes |
| dst | input | 128 | Old destination vector used when accumulating |
| is_unsigned | input | 1 | 1: zero-extend elements, 0: sign-extend |
| accumulate | input | 1 | 1: add pair sums to dst lanes |
| lane_size | input | 2 | Source lane width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| full_vec | input | 1 | 1: both 64-bit halves, 0: low half only with upper result zero |
| out_valid | output | 1 | Result register holds an unaccepted result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 128 | Widened, optionally accumulated result |
| out_err | output | 1 | One-cycle pulse after an illegal lane size is accepted |

## Verification
The hardest case to reach is an accumulate add that carries out of the top of one wide lane. Such a carry must be dropped rather than passed into the next lane. To hit it at every lane width, the stimulus pairs all-ones and maximum-magnitude sources with an all-ones destination. The second hard case is a new operation presented while the output is stalled. The bench holds out_ready low across a second offered operation, then releases it, to show that the stall holds the old result and that the second operation is taken afterwards.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  typedef enum logic [1:0] {
    LS_B8  = 2'd0,
    LS_H16 = 2'd1,
    LS_W32 = 2'd2,
    LS_BAD = 2'd3
  } lane_sz_e;

  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned BASE_W    = 8;
endpackage

// File: rtl/pwa_rst_sync.sv
module pwa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pwa_pair_add.sv
module pwa_pair_add #(
  parameter int unsigned DW = 128,
  parameter int unsigned NW = 8
) (
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic          is_unsigned,
  input  logic          accumulate,
  output logic [DW-1:0] sum
);
  localparam int unsigned WW    = 2 * NW;
  localparam int unsigned LANES = DW / WW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [NW-1:0] lo_el, hi_el;
    logic [WW-1:0] lo_ext, hi_ext, acc_term;

    assign lo_el    = src[k*WW +: NW];
    assign hi_el    = src[k*WW+NW +: NW];
    assign lo_ext   = {{NW{~is_unsigned & lo_el[NW-1]}}, lo_el};
    assign hi_ext   = {{NW{~is_unsigned & hi_el[NW-1]}}, hi_el};
    assign acc_term = accumulate ? dst[k*WW +: WW] : '0;
    assign sum[k*WW +: WW] = lo_ext + hi_ext + acc_term;
  end
endmodule

// File: rtl/pwa_datapath.sv
module pwa_datapath
  import pwa_pkg::*;
#(
  parameter int unsigned DW = 128
) (
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic          is_unsigned,
  input  logic          accumulate,
  input  logic [1:0]    lane_size,
  input  logic          full_vec,
  output logic [DW-1:0] res
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] cand [NUM_SIZES];
  logic [DW-1:0] picked;
  lane_sz_e      sz;

  assign sz = lane_sz_e'(lane_size);

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    pwa_pair_add #(
      .DW (DW),
      .NW (BASE_W << s)
    ) u_pair (
      .src         (src),
      .dst         (dst),
      .is_unsigned (is_unsigned),
      .accumulate  (accumulate),
      .sum         (cand[s])
    );
  end

  always_comb begin
    case (sz)
      LS_B8:   picked = cand[0];
      LS_H16:  picked = cand[1];
      LS_W32:  picked = cand[2];
      default: picked = '0;
    endcase
  end

  assign res = full_vec ? picked : {{HW{1'b0}}, picked[HW-1:0]};
endmodule

// File: rtl/pwa_ctrl.sv
module pwa_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic legal,
  output logic in_ready,
  output logic load,
  output logic out_valid,
  output logic out_err
);
  logic valid_q, valid_d;
  logic err_q, err_d;
  logic take;

  assign in_ready = ~valid_q | out_ready;
  assign take     = in_valid & in_ready;
  assign load     = take & legal;

  always_comb begin
    valid_d = valid_q;
    if (take)           valid_d = legal;
    else if (out_ready) valid_d = 1'b0;
    err_d = take & ~legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
endmodule

// File: rtl/pwa_widen_acc.sv
module pwa_widen_acc
  import pwa_pkg::*;
#(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic          is_unsigned,
  input  logic          accumulate,
  input  logic [1:0]    lane_size,
  input  logic          full_vec,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result,
  output logic          out_err
);
  logic          rst_n_int;
  logic          legal;
  logic          load;
  logic [DW-1:0] dp_res;
  logic [DW-1:0] res_q, res_d;

  pwa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign legal = (lane_size != LS_BAD);

  pwa_datapath #(.DW(DW)) u_dp (
    .src         (src),
    .dst         (dst),
    .is_unsigned (is_unsigned),
    .accumulate  (accumulate),
    .lane_size   (lane_size),
    .full_vec    (full_vec),
    .res         (dp_res)
  );

  pwa_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .legal     (legal),
    .in_ready  (in_ready),
    .load      (load),
    .out_valid (out_valid),
    .out_err   (out_err)
  );

  always_comb begin
    res_d = res_q;
    if (load) res_d = dp_res;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) res_q <= '0;
    else            res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/pwa_checker.sv
module pwa_checker #(
  parameter int unsigned DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_err,
  input logic          full_vec,
  input logic [1:0]    lane_size,
  input logic [DW-1:0] result
);
  localparam int unsigned HW = DW / 2;

  p_half_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lane_size != 2'd3 && !full_vec) |=> (result[DW-1:HW] == '0));

  p_illegal_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lane_size == 2'd3) |=> (out_err && !out_valid && $stable(result)));

  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_valid);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lane_size != 2'd3) |=> out_valid);

  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));
endmodule

bind pwa_widen_acc pwa_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_err   (out_err),
  .full_vec  (full_vec),
  .lane_size (lane_size),
  .result    (result)
);

// File: tb/pwa_widen_acc_bench.sv
`timescale 1ns/1ps
module pwa_widen_acc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src = '0;
  logic [127:0] dst = '0;
  logic         is_unsigned = 1'b0;
  logic         accumulate = 1'b0;
  logic [1:0]   lane_size = 2'd0;
  logic         full_vec = 1'b1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] result;
  logic         out_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwa_widen_acc u_pwa_widen_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .dst(dst), .is_unsigned(is_unsigned), .accumulate(accumulate),
    .lane_size(lane_size), .full_vec(full_vec), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .out_err(out_err)
  );

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic u, input logic a,
                                         input int sz, input logic f);
    int n = 8 << sz;
    logic [127:0] nmask = (128'd1 << n) - 1;
    logic [127:0] wmask = (128'd1 << (2*n)) - 1;
    logic [127:0] r = '0;
    for (int k = 0; k < 128/(2*n); k++) begin
      logic [127:0] ea = (s >> (2*k*n)) & nmask;
      logic [127:0] eb = (s >> ((2*k+1)*n)) & nmask;
      logic [127:0] lane;
      if (!u && ea[n-1]) ea = ea | ~nmask;
      if (!u && eb[n-1]) eb = eb | ~nmask;
      lane = ea + eb;
      if (a) lane = lane + ((d >> (2*k*n)) & wmask);
      r = r | ((lane & wmask) << (2*k*n));
    end
    if (!f) r[127:64] = '0;
    return r;
  endfunction

  task automatic check_vec(input logic [127:0] act, input logic [127:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] s, input logic [127:0] d, input logic u,
                       input logic a, input logic [1:0] sz, input logic f);
    @(negedge clk);
    src = s; dst = d; is_unsigned = u; accumulate = a; lane_size = sz; full_vec = f;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic op_check(input logic [127:0] s, input logic [127:0] d, input logic u,
                          input logic a, input int sz, input logic f, input string tag);
    logic [127:0] e;
    e = model(s, d, u, a, sz, f);
    issue(s, d, u, a, 2'(sz), f);
    check_bit(out_valid, 1'b1, {tag, " R7 valid"});
    check_vec(result, e, tag);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] pats [6];
    logic [127:0] dpats [2];
    logic [127:0] held;
    logic [127:0] e;

    pats[0] = {128{1'b1}};
    pats[1] = {16{8'h80}};
    pats[2] = {16{8'h7f}};
    pats[3] = {$urandom, $urandom, $urandom, $urandom};
    pats[4] = {$urandom, $urandom, $urandom, $urandom};
    pats[5] = {64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210};
    dpats[0] = {128{1'b1}};
    dpats[1] = {$urandom, $urandom, $urandom, $urandom};

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_bit(out_valid, 1'b0, "R9 out_valid");
    check_bit(out_err, 1'b0, "R9 out_err");
    check_vec(result, '0, "R9 result");
    check_bit(in_ready, 1'b1, "R9 in_ready");

    // directed sign/zero extension at each size
    op_check({112'd0, 16'hff_ff}, '0, 1'b0, 1'b0, 0, 1'b1, "R2 signed8");
    check_vec(result[15:0], 16'hfffe, "R2 signed8 lane0");
    op_check({112'd0, 16'hff_ff}, '0, 1'b1, 1'b0, 0, 1'b1, "R2 unsigned8");
    check_vec(result[15:0], 16'h01fe, "R2 unsigned8 lane0");
    op_check({64'd0, 64'h8000_0000_8000_0000}, '0, 1'b0, 1'b0, 2, 1'b1, "R3 w32");
    check_vec(result[63:0], 64'hffff_ffff_0000_0000, "R3 w32 lane0");
    op_check({96'd0, 32'h0001_0001}, '0, 1'b1, 1'b0, 1, 1'b1, "R3 h16");
    check_vec(result[31:0], 32'd2, "R3 h16 lane0");

    // carry containment at every width: all-ones source plus all-ones dst
    for (int sz = 0; sz < 3; sz++) begin
      op_check({128{1'b1}}, {128{1'b1}}, 1'b1, 1'b1, sz, 1'b1, "R4 carry wrap");
    end

    // half mode ignores upper source and zeroes upper result, also with accumulate
    op_check({64'hffff_ffff_ffff_ffff, 64'd3}, {128{1'b1}}, 1'b1, 1'b1, 0, 1'b0, "R5 half acc");
    check_vec(result[127:64], '0, "R5 upper zero");

    // sweep
    for (int sz = 0; sz < 3; sz++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 2; a++)
          for (int f = 0; f < 2; f++)
            for (int p = 0; p < 6; p++)
              op_check(pats[p], dpats[p % 2], 1'(u), 1'(a), sz, 1'(f),
                       $sformatf("R1 R2 R3%s%s sz=%0d u=%0d", (a != 0) ? " R4" : "",
                                 (f != 0) ? "" : " R5", sz, u));

    // illegal lane size
    e = model(pats[3], '0, 1'b0, 1'b0, 1, 1'b1);
    op_check(pats[3], '0, 1'b0, 1'b0, 1, 1'b1, "R6 prior");
    issue(pats[4], pats[5], 1'b0, 1'b1, 2'd3, 1'b1);
    check_bit(out_err, 1'b1, "R6 err pulse");
    check_bit(out_valid, 1'b0, "R6 no valid");
    check_vec(result, e, "R6 result kept");
    @(posedge clk); #1;
    check_bit(out_err, 1'b0, "R6 err one cycle");

    // backpressure
    @(negedge clk);
    out_ready = 1'b0;
    e = model(pats[5], pats[3], 1'b0, 1'b1, 0, 1'b1);
    issue(pats[5], pats[3], 1'b0, 1'b1, 2'd0, 1'b1);
    check_bit(out_valid, 1'b1, "R7 valid under stall");
    check_vec(result, e, "R7 first result");
    held = result;
    @(negedge clk);
    src = pats[4]; dst = '0; is_unsigned = 1'b1; accumulate = 1'b0; lane_size = 2'd2; full_vec = 1'b1;
    in_valid = 1'b1;
    #1;
    check_bit(in_ready, 1'b0, "R8 ready low");
    repeat (3) @(posedge clk);
    #1;
    check_bit(out_valid, 1'b1, "R8 valid held");
    check_vec(result, held, "R8 result held");
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check_bit(in_ready, 1'b1, "R7 ready on accept");
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_vec(result, model(pats[4], '0, 1'b1, 1'b0, 2, 1'b1), "R7 second taken");
    @(posedge clk); #1;
    check_bit(out_valid, 1'b0, "R7 drained");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule